// File: doc/BRIEF.md
# Oscillator Disciplining IIR Loop Filter

This block is the arithmetic core of a frequency-disciplining loop. Once per update period it takes one accumulated time-interval count. It forms the phase error against a programmable setpoint and clips that error to a programmable bound. It then smooths the error with a shift-based first-order low-pass filter and adds a gain-scaled copy of the filter output to the word that drives the oscillator's tuning DAC. The DAC word saturates at both ends and never wraps.

The time constant of the filter comes from a mode input. The shift used by each mode is offset by two parameters. One raises the shift to suit the counter's resolution, and the other lowers it to make up for a long update period. With that offset, the longest modes keep settle times of a few hours rather than days. Internally the filter carries fractional bits, so small errors still move its state. Each accepted sample yields a new DAC word on the next clock, marked by a one-cycle strobe.

Top module: `osc_loop_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the DAC word is loaded with midscale (only the top bit of the DAC word set), the update strobe is cleared and the filter state is cleared to zero.
- R2: For each accepted sample, the raw error is the sample minus the setpoint, both taken as unsigned and the difference taken as signed.
- R3: The raw error is clipped to the range from minus `limit` to plus `limit` before it reaches the filter.
- R4: The filter holds a signed state y with FRAC_W fractional bits. For each sample, x is the clipped error shifted left by FRAC_W, and y becomes y + ((x − y) arithmetically shifted right by k).
- R5: The filter shift is k = mode + MODE_BASE − PERIOD_ADJ, floored at 0. With the default values, modes 0 and 1 give k = 0 (no smoothing) and mode 7 gives k = 6.
- R6: The correction is the updated y arithmetically shifted right by FRAC_W, then arithmetically shifted right again by `gain_shift`. Both shifts round toward minus infinity.
- R7: The new DAC word is the old word plus the correction, held at 0 when the sum is negative and at 2^DAC_W − 1 when the sum exceeds it.
- R8: `dac_update` is high for exactly the one cycle that follows each cycle in which `sample_valid` is high. The new DAC word appears in that same cycle.
- R9: In a cycle where `sample_valid` is low, the sample, setpoint, limit, mode and gain inputs have no effect: the DAC word and the filter state both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Qualifies `sample` for one cycle |
| sample | input | SAMPLE_W | Accumulated interval count for one update period |
| setpoint | input | SAMPLE_W | Count that corresponds to zero phase error |
| limit | input | SAMPLE_W | Magnitude bound on the error |
| mode | input | MODE_W | Filter time-constant selector |
| gain_shift | input | GAIN_W | Right shift that sets the loop gain |
| dac_word | output | DAC_W | Tuning DAC word |
| dac_update | output | 1 | One-cycle strobe when a new DAC word is out |

## Verification
Some properties are checked on every cycle: the reset values, the strobe following each valid sample by one cycle, the DAC word holding steady between samples, the clipped error staying inside the bound, and the DAC word moving in the direction of the correction's sign without wrapping. Other behaviour is visible only in the bench's scenarios. These include the exact filter recursion for each mode, the rounding of the two arithmetic shifts, and saturation at both rails under sustained errors. They also include proof that reset zeroes the filter state and that inputs changed without a valid sample have no effect. The bench checks them against an integer model, sweeping every mode, several gains and limits, and every sample value of a narrow configuration.

// File: rtl/ofl_pkg.sv
// Shared helpers for the oscillator loop filter.
// Assumes mode and offset values are small non-negative integers.
package ofl_pkg;

    // Map a mode selector onto the filter's right-shift amount, floored at zero.
    function automatic int unsigned mode_to_shift(input int unsigned mode_val,
                                                  input int unsigned base,
                                                  input int unsigned adj);
        if (mode_val + base > adj)
            return mode_val + base - adj;
        else
            return 0;
    endfunction

endpackage

// File: rtl/ofl_err_limiter.sv
// Error former and limiter.
// Subtracts the setpoint from the sample and clips the signed difference
// to +/- limit. Purely combinational. Assumes both operands are unsigned.
module ofl_err_limiter #(
    parameter int SAMPLE_W = 24,
    localparam int ERR_W   = SAMPLE_W + 1
) (
    input  logic [SAMPLE_W-1:0]     sample,
    input  logic [SAMPLE_W-1:0]     setpoint,
    input  logic [SAMPLE_W-1:0]     limit,
    output logic signed [ERR_W-1:0] clamped
);
    logic signed [ERR_W-1:0] raw_err;
    logic signed [ERR_W-1:0] lim_pos;
    logic signed [ERR_W-1:0] lim_neg;

    // Form the signed error and clip it to the symmetric bound.
    always_comb begin
        raw_err = $signed({1'b0, sample}) - $signed({1'b0, setpoint});
        lim_pos = $signed({1'b0, limit});
        lim_neg = -lim_pos;
        if (raw_err > lim_pos)
            clamped = lim_pos;
        else if (raw_err < lim_neg)
            clamped = lim_neg;
        else
            clamped = raw_err;
    end
endmodule

// File: rtl/ofl_iir_stage.sv
// First-order shift-based IIR low-pass filter.
// y <= y + ((x - y) >>> k), where x is the clipped error with FRAC_W
// fractional bits appended. The state moves only on load. y_next is the
// value the state takes on a load, so a consumer can act in the same cycle.
// Assumes |x| and |y| stay within the clipped error range, so the
// difference fits in ACC_W bits.
module ofl_iir_stage #(
    parameter int ERR_W      = 25,
    parameter int FRAC_W     = 8,
    parameter int MODE_W     = 3,
    parameter int MODE_BASE  = 1,
    parameter int PERIOD_ADJ = 2,
    localparam int ACC_W     = ERR_W + FRAC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [MODE_W-1:0]       mode,
    input  logic signed [ERR_W-1:0] x_err,
    output logic signed [ACC_W-1:0] y_next
);
    logic signed [ACC_W-1:0] y_q;
    logic signed [ACC_W-1:0] x_fix;
    logic signed [ACC_W-1:0] diff;
    int unsigned             k;

    // Scale the error into fixed point and compute the filter step.
    always_comb begin
        x_fix  = $signed({x_err[ERR_W-1], x_err, {FRAC_W{1'b0}}});
        diff   = x_fix - y_q;
        k      = ofl_pkg::mode_to_shift(int'(mode), MODE_BASE, PERIOD_ADJ);
        y_next = y_q + (diff >>> k);
    end

    // Hold the filter state; update only on an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_q <= '0;
        else if (load)
            y_q <= y_next;
    end
endmodule

// File: rtl/ofl_gain_scale.sv
// Loop gain stage.
// Drops the filter's fractional bits, then applies the gain right shift.
// Both shifts are arithmetic, so negative values round toward minus infinity.
module ofl_gain_scale #(
    parameter int ACC_W  = 34,
    parameter int FRAC_W = 8,
    parameter int GAIN_W = 5
) (
    input  logic signed [ACC_W-1:0] y_in,
    input  logic [GAIN_W-1:0]       gain_shift,
    output logic signed [ACC_W-1:0] delta
);
    logic signed [ACC_W-1:0] y_int;

    // Integer part of the filter output, scaled by the loop gain.
    always_comb begin
        y_int = y_in >>> FRAC_W;
        delta = y_int >>> gain_shift;
    end
endmodule

// File: rtl/ofl_dac_accum.sv
// Saturating DAC word accumulator.
// Adds a signed correction to the unsigned DAC word and holds the result
// between 0 and 2^DAC_W-1. Registers the word and a one-cycle strobe.
// Reset loads midscale.
module ofl_dac_accum #(
    parameter int ACC_W = 34,
    parameter int DAC_W = 23,
    localparam int SUM_W = ((ACC_W > DAC_W) ? ACC_W : DAC_W) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] delta,
    output logic [DAC_W-1:0]        dac_word,
    output logic                    dac_update
);
    localparam logic [DAC_W-1:0] MID_WORD = {1'b1, {(DAC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] MAX_S =
        $signed({{(SUM_W-DAC_W){1'b0}}, {DAC_W{1'b1}}});

    logic signed [SUM_W-1:0] sum;
    logic [DAC_W-1:0]        sat_word;

    // Widen, add and clip the result to the DAC range.
    always_comb begin
        sum = $signed({{(SUM_W-DAC_W){1'b0}}, dac_word})
            + $signed({{(SUM_W-ACC_W){delta[ACC_W-1]}}, delta});
        if (sum[SUM_W-1])
            sat_word = '0;
        else if (sum > MAX_S)
            sat_word = {DAC_W{1'b1}};
        else
            sat_word = sum[DAC_W-1:0];
    end

    // Register the DAC word and raise the strobe for one cycle per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word   <= MID_WORD;
            dac_update <= 1'b0;
        end else begin
            dac_update <= load;
            if (load)
                dac_word <= sat_word;
        end
    end
endmodule

// File: rtl/osc_loop_filter.sv
// Oscillator disciplining loop filter, top level.
// One sample per update period goes through error forming and limiting,
// the IIR filter, the gain scaling and the saturating DAC accumulator.
// The new DAC word follows each valid sample by one clock.
// Assumes sample_valid is high for one cycle per sample.
module osc_loop_filter #(
    parameter int SAMPLE_W   = 24,
    parameter int DAC_W      = 23,
    parameter int FRAC_W     = 8,
    parameter int MODE_W     = 3,
    parameter int GAIN_W     = 5,
    parameter int MODE_BASE  = 1,
    parameter int PERIOD_ADJ = 2,
    localparam int ERR_W     = SAMPLE_W + 1,
    localparam int ACC_W     = ERR_W + FRAC_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] setpoint,
    input  logic [SAMPLE_W-1:0] limit,
    input  logic [MODE_W-1:0]   mode,
    input  logic [GAIN_W-1:0]   gain_shift,
    output logic [DAC_W-1:0]    dac_word,
    output logic                dac_update
);
    logic signed [ERR_W-1:0] clamped_err;
    logic signed [ACC_W-1:0] filt_next;
    logic signed [ACC_W-1:0] corr_delta;

    ofl_err_limiter #(.SAMPLE_W(SAMPLE_W)) u_limiter (
        .sample   (sample),
        .setpoint (setpoint),
        .limit    (limit),
        .clamped  (clamped_err)
    );

    ofl_iir_stage #(
        .ERR_W(ERR_W), .FRAC_W(FRAC_W), .MODE_W(MODE_W),
        .MODE_BASE(MODE_BASE), .PERIOD_ADJ(PERIOD_ADJ)
    ) u_iir (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sample_valid),
        .mode   (mode),
        .x_err  (clamped_err),
        .y_next (filt_next)
    );

    ofl_gain_scale #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W)) u_gain (
        .y_in       (filt_next),
        .gain_shift (gain_shift),
        .delta      (corr_delta)
    );

    ofl_dac_accum #(.ACC_W(ACC_W), .DAC_W(DAC_W)) u_dac (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sample_valid),
        .delta      (corr_delta),
        .dac_word   (dac_word),
        .dac_update (dac_update)
    );
endmodule

// File: rtl/osc_loop_filter_chk.sv
// Property checker for the oscillator loop filter, bound to every instance.
module osc_loop_filter_chk #(
    parameter int SAMPLE_W = 24,
    parameter int DAC_W    = 23,
    parameter int ERR_W    = 25,
    parameter int ACC_W    = 34
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_valid,
    input logic [SAMPLE_W-1:0]     limit,
    input logic signed [ERR_W-1:0] clamped_err,
    input logic signed [ACC_W-1:0] corr_delta,
    input logic [DAC_W-1:0]        dac_word,
    input logic                    dac_update
);
    localparam logic [DAC_W-1:0] MID_WORD = {1'b1, {(DAC_W-1){1'b0}}};

    logic signed [ERR_W-1:0] lim_s;
    assign lim_s = $signed({1'b0, limit});

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_word == MID_WORD && !dac_update));

    // R8
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> dac_update);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(dac_word) && !dac_update));

    // R3
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (clamped_err <= lim_s && clamped_err >= -lim_s));

    // R7
    rise_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !corr_delta[ACC_W-1]) |=> dac_word >= $past(dac_word));

    // R7
    fall_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && corr_delta[ACC_W-1]) |=> dac_word <= $past(dac_word));
endmodule

bind osc_loop_filter osc_loop_filter_chk #(
    .SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W), .ERR_W(ERR_W), .ACC_W(ACC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .limit        (limit),
    .clamped_err  (clamped_err),
    .corr_delta   (corr_delta),
    .dac_word     (dac_word),
    .dac_update   (dac_update)
);

// File: tb/osc_loop_filter_test.sv
`timescale 1ns/1ps
// Sweeps a narrow configuration against an integer model of the loop.
module osc_loop_filter_test;
    localparam int SW = 8, DW = 10, FW = 4, MW = 3, GW = 3;
    localparam longint DMAX = (64'sd1 <<< DW) - 1;
    localparam longint DMID = 64'sd1 <<< (DW - 1);

    logic clk = 1'b0, rst_n = 1'b0, sample_valid = 1'b0;
    logic [SW-1:0] sample = '0, setpoint = '0, limit = '0;
    logic [MW-1:0] mode = '0;
    logic [GW-1:0] gain_shift = '0;
    logic [DW-1:0] dac_word;
    logic dac_update;

    int checks = 0, fails = 0;
    longint m_y = 0, m_dac = DMID;

    always #2.5 clk = ~clk;

    osc_loop_filter #(.SAMPLE_W(SW), .DAC_W(DW), .FRAC_W(FW),
                      .MODE_W(MW), .GAIN_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample(sample), .setpoint(setpoint), .limit(limit),
        .mode(mode), .gain_shift(gain_shift),
        .dac_word(dac_word), .dac_update(dac_update));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of R2..R7 for one accepted sample.
    task automatic model_step(input int s, input int sp, input int lim,
                              input int md, input int g);
        longint e, x, k, d;
        e = longint'(s) - longint'(sp);                  // R2
        if (e > lim) e = lim; else if (e < -lim) e = -lim; // R3
        k = md + 1 - 2; if (k < 0) k = 0;                // R5
        x = e * (64'sd1 <<< FW);                         // R4
        m_y = m_y + ((x - m_y) >>> k);
        d = (m_y >>> FW) >>> g;                          // R6
        m_dac = m_dac + d;                               // R7
        if (m_dac < 0) m_dac = 0;
        if (m_dac > DMAX) m_dac = DMAX;
    endtask

    task automatic apply(input int s, input int sp, input int lim,
                         input int md, input int g);
        @(negedge clk);
        check("R8 strobe low between samples", longint'(dac_update), 0);
        sample = SW'(s); setpoint = SW'(sp); limit = SW'(lim);
        mode = MW'(md); gain_shift = GW'(g); sample_valid = 1'b1;
        model_step(s, sp, lim, md, g);
        @(negedge clk);
        sample_valid = 1'b0;
        check("R8 strobe after sample", longint'(dac_update), 1);
        check("R2 R3 R4 R5 R6 R7 dac word", longint'(dac_word), m_dac);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset dac midscale", longint'(dac_word), DMID);
        check("R1 reset strobe low", longint'(dac_update), 0);
        rst_n = 1'b1;
        m_y = 0; m_dac = DMID;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // Sweep every mode and several gains over all sample values.
        for (int md = 0; md < 8; md++) begin
            for (int gi = 0; gi < 3; gi++) begin
                int g, lim, sp;
                g = (gi == 0) ? 0 : ((gi == 1) ? 2 : 5);
                lim = (md * 37 + gi * 29 + 13) % 256;
                sp = 96 + md * 8;
                for (int i = 0; i < 256; i++)
                    apply((i * 73 + md * 11 + gi) & 255, sp, lim, md, g);
            end
        end
        // R7: sustained positive error drives the word to the top rail.
        for (int i = 0; i < 12; i++) apply(255, 0, 255, 0, 0);
        check("R7 top rail", longint'(dac_word), DMAX);
        // R7: sustained negative error drives it to zero.
        for (int i = 0; i < 12; i++) apply(0, 255, 255, 0, 0);
        check("R7 bottom rail", longint'(dac_word), 0);
        apply(200, 100, 50, 3, 1);
        // R9: inputs change without a valid sample; nothing moves.
        begin
            longint held;
            held = longint'(dac_word);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                sample = SW'(i * 40); setpoint = SW'(255 - i);
                limit = 8'hff; mode = MW'(i); gain_shift = GW'(0);
                check("R9 dac held without valid", longint'(dac_word), held);
                check("R9 no strobe without valid", longint'(dac_update), 0);
            end
        end
        apply(128, 128, 40, 7, 0);   // R9: model state unchanged shows filter held
        // R1: reset mid-run clears the filter state as well.
        do_reset();
        apply(77, 77, 100, 7, 0);
        check("R1 filter state zero after reset", longint'(dac_word), DMID);
        apply(90, 77, 100, 7, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule